// File: doc/BRIEF.md
# Boundary Scan Cell Chain

This block is a parameterised chain of boundary scan cells for a set of bidirectional pads, a set of input-only pads and a few internal-only cells. A test access port controller outside the block supplies a select signal, three single-cycle strobes (capture, shift and update) and a mode code. Every cell has a shift stage and an update stage. The shift stages form one serial path from `scan_in` to `scan_out`. The update stages hold the values that are applied to the pads or to the core.

In functional mode the core signals pass straight through to the pads. In external-test mode the update stages drive the pads. In internal-test mode the update stages of the input cells feed the core. Which cells load during capture depends on the mode.

A bidirectional pad disabled by its control cell, or by the global `all_off` input, is modelled as pulled up to 1.

Top module: `bscan_chain`

## Requirements
- R1: The chain length is L = NB_INONLY + NB_INTERNAL + 3*NB_BIDIR.
  - Cell 0 drives `scan_out` combinationally.
  - Input-only pad j is cell j.
  - Internal cell k is cell NB_INONLY+k.
  - Bidirectional pad p uses cells B=NB_INONLY+NB_INTERNAL+3p (control), B+1 (output) and B+2 (input).
  - In a shift cycle (sel=1, shift_en=1, capture_en=0), every shift stage takes the value of the next higher cell, and cell L-1 takes `scan_in`.
- R2: Update stages copy the shift stages only in a cycle with sel=1 and update_en=1. In every other cycle they hold.
- R3: Reset (rst_n=0, asynchronous) clears all shift stages and all update stages to 0, except control and internal update stages, which are set to 1.
- R4: With mode=1 (external test):
  - `pad_oe[p]` is the inverse of the control update stage of pad p, and `pad_out[p]` is its output update stage.
  - A control value of 1 disables the pad.
  - In every mode, a pad whose `pad_oe` is 0 shows `pad_out`=1.
- R5: With mode=0 or 3 (functional/sample), a capture cycle (sel=1, capture_en=1) loads every cell from live values:
  - input cells load `pad_in` or `ipad_in`;
  - output cells load `core_out`;
  - control cells load the inverse of `core_oe`.
  - The pads follow `core_out` and `core_oe`, and the core sees `pad_in` and `ipad_in`.
- R6: With mode=1, a capture cycle loads only the input cells. Output and control shift stages keep their values.
- R7: With mode=2 (internal test), a capture cycle leaves the input cells unchanged and loads the output and control cells. `core_in` and `icore_in` come from the update stages of the input cells, and the pads act functionally.
- R8: While sel=0, the shift stages ignore the capture and shift strobes.
- R9: When `all_off`=1, every `pad_oe` bit is 0 in every mode.
- R10: An internal cell drives no pad. In a capture cycle it loads its own update-stage value.
- R11: When capture_en and shift_en are both high in a selected cycle, the capture takes place and no shift occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Boundary register selected |
| capture_en | input | 1 | Capture strobe |
| shift_en | input | 1 | Shift strobe |
| update_en | input | 1 | Update strobe |
| mode | input | 2 | 0/3 functional-sample, 1 external test, 2 internal test |
| scan_in | input | 1 | Serial input into cell L-1 |
| scan_out | output | 1 | Serial output from cell 0 |
| all_off | input | 1 | Forces every pad output enable low |
| core_out | input | NB_BIDIR | Core data toward the pads |
| core_oe | input | NB_BIDIR | Core output enables (1 = drive) |
| core_in | output | NB_BIDIR | Pad data toward the core |
| pad_in | input | NB_BIDIR | Levels seen on the bidirectional pads |
| pad_out | output | NB_BIDIR | Pad drive value (1 when disabled) |
| pad_oe | output | NB_BIDIR | Pad output enables |
| ipad_in | input | NB_INONLY | Levels on the input-only pads |
| icore_in | output | NB_INONLY | Input-only pad data toward the core |

## Verification
The hardest cases to reach from the ports are the mode-dependent captures, because their result becomes visible only after a full unload of L shift cycles. The same holds for the capture-over-shift priority.

The stimulus captures under each mode with pad and core values that differ bit by bit from the data already in the chain, so that any cell loading when it should hold shows up in the serial stream. A random phase then mixes strobes, modes, the select signal and `all_off`. A behavioural model checks every output on every clock.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

  typedef enum logic [1:0] {
    BS_PASS  = 2'd0,
    BS_EXT   = 2'd1,
    BS_INT   = 2'd2,
    BS_PASS2 = 2'd3
  } bs_mode_e;

  typedef enum logic [2:0] {
    KIND_IONLY = 3'd0,
    KIND_INTRN = 3'd1,
    KIND_CTL   = 3'd2,
    KIND_OUT   = 3'd3,
    KIND_IN    = 3'd4
  } bs_kind_e;

  // Role of a cell from its chain position.
  function automatic bs_kind_e cell_kind(input int idx, input int n_ionly, input int n_int);
    int rel;
    if (idx < n_ionly) return KIND_IONLY;
    if (idx < n_ionly + n_int) return KIND_INTRN;
    rel = (idx - n_ionly - n_int) % 3;
    if (rel == 0) return KIND_CTL;
    if (rel == 1) return KIND_OUT;
    return KIND_IN;
  endfunction

  // Whether a cell of this role loads in a capture cycle under this mode.
  function automatic logic capture_taken(input bs_kind_e k, input bs_mode_e m);
    case (k)
      KIND_IONLY, KIND_IN: return (m != BS_INT);
      KIND_CTL, KIND_OUT:  return (m != BS_EXT);
      default:             return 1'b1;
    endcase
  endfunction

  // Value that the update stage holds after reset.
  function automatic logic safe_value(input bs_kind_e k);
    return (k == KIND_CTL) || (k == KIND_INTRN);
  endfunction

endpackage

// File: rtl/bscan_cell.sv
module bscan_cell #(
  parameter logic SAFE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cap_take,
  input  logic cap_d,
  input  logic shift_take,
  input  logic shift_d,
  input  logic upd_take,
  output logic sh_q,
  output logic up_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= 1'b0;
      up_q <= SAFE;
    end else begin
      if (cap_take)        sh_q <= cap_d;
      else if (shift_take) sh_q <= shift_d;
      if (upd_take)        up_q <= sh_q;
    end
  end
endmodule

// File: rtl/bscan_pin_mux.sv
module bscan_pin_mux (
  input  logic ext_mode,
  input  logic int_mode,
  input  logic all_off,
  input  logic core_out,
  input  logic core_oe,
  input  logic pad_in,
  input  logic up_out,
  input  logic up_ctl,
  input  logic up_in,
  output logic pad_out,
  output logic pad_oe,
  output logic core_in
);
  logic drv_d, drv_en;

  always_comb begin
    drv_d   = ext_mode ? up_out : core_out;
    drv_en  = ext_mode ? ~up_ctl : core_oe;
    pad_oe  = drv_en & ~all_off;
    pad_out = pad_oe ? drv_d : 1'b1;   // a disabled pad floats up to 1
    core_in = int_mode ? up_in : pad_in;
  end
endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
  import bscan_pkg::*;
#(
  parameter int NB_BIDIR    = 4,
  parameter int NB_INONLY   = 2,
  parameter int NB_INTERNAL = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sel,
  input  logic                 capture_en,
  input  logic                 shift_en,
  input  logic                 update_en,
  input  logic [1:0]           mode,
  input  logic                 scan_in,
  output logic                 scan_out,
  input  logic                 all_off,
  input  logic [NB_BIDIR-1:0]  core_out,
  input  logic [NB_BIDIR-1:0]  core_oe,
  output logic [NB_BIDIR-1:0]  core_in,
  input  logic [NB_BIDIR-1:0]  pad_in,
  output logic [NB_BIDIR-1:0]  pad_out,
  output logic [NB_BIDIR-1:0]  pad_oe,
  input  logic [NB_INONLY-1:0] ipad_in,
  output logic [NB_INONLY-1:0] icore_in
);
  localparam int L     = NB_INONLY + NB_INTERNAL + 3 * NB_BIDIR;
  localparam int BBASE = NB_INONLY + NB_INTERNAL;

  bs_mode_e mode_e;
  logic     cap_fire, shf_fire, upd_fire;
  logic     ext_mode, int_mode;
  logic [L-1:0] sh_vec, up_vec, cap_d, cap_take, shift_d;

  assign mode_e   = bs_mode_e'(mode);
  assign cap_fire = sel & capture_en;
  assign shf_fire = sel & shift_en & ~capture_en;
  assign upd_fire = sel & update_en;
  assign ext_mode = (mode_e == BS_EXT);
  assign int_mode = (mode_e == BS_INT);
  assign scan_out = sh_vec[0];

  for (genvar i = 0; i < L; i++) begin : g_cell
    localparam bs_kind_e K = cell_kind(i, NB_INONLY, NB_INTERNAL);

    if (K == KIND_IONLY) begin : g_io
      assign cap_d[i] = ipad_in[i];
    end else if (K == KIND_INTRN) begin : g_it
      assign cap_d[i] = up_vec[i];
    end else begin : g_bd
      localparam int P = (i - BBASE) / 3;
      if (K == KIND_CTL) begin : g_c
        assign cap_d[i] = ~core_oe[P];
      end else if (K == KIND_OUT) begin : g_o
        assign cap_d[i] = core_out[P];
      end else begin : g_i
        assign cap_d[i] = pad_in[P];
      end
    end

    assign cap_take[i] = cap_fire & capture_taken(K, mode_e);

    if (i == L - 1) begin : g_top
      assign shift_d[i] = scan_in;
    end else begin : g_mid
      assign shift_d[i] = sh_vec[i+1];
    end

    bscan_cell #(.SAFE(safe_value(K))) u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap_take  (cap_take[i]),
      .cap_d     (cap_d[i]),
      .shift_take(shf_fire),
      .shift_d   (shift_d[i]),
      .upd_take  (upd_fire),
      .sh_q      (sh_vec[i]),
      .up_q      (up_vec[i])
    );
  end

  for (genvar p = 0; p < NB_BIDIR; p++) begin : g_pin
    localparam int B = BBASE + 3 * p;
    bscan_pin_mux u_mux (
      .ext_mode(ext_mode),
      .int_mode(int_mode),
      .all_off (all_off),
      .core_out(core_out[p]),
      .core_oe (core_oe[p]),
      .pad_in  (pad_in[p]),
      .up_out  (up_vec[B+1]),
      .up_ctl  (up_vec[B]),
      .up_in   (up_vec[B+2]),
      .pad_out (pad_out[p]),
      .pad_oe  (pad_oe[p]),
      .core_in (core_in[p])
    );
  end

  for (genvar j = 0; j < NB_INONLY; j++) begin : g_ipin
    assign icore_in[j] = int_mode ? up_vec[j] : ipad_in[j];
  end
endmodule

// File: rtl/bscan_chain_chk.sv
module bscan_chain_chk #(
  parameter int L  = 15,
  parameter int NB = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sel,
  input logic          capture_en,
  input logic          shift_en,
  input logic          update_en,
  input logic          scan_in,
  input logic          all_off,
  input logic [NB-1:0] pad_out,
  input logic [NB-1:0] pad_oe,
  input logic [L-1:0]  sh_vec,
  input logic [L-1:0]  up_vec
);
  a_r1_shift_step: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && shift_en && !capture_en) |=>
      (sh_vec[L-1] == $past(scan_in)) && (sh_vec[L-2:0] == $past(sh_vec[L-1:1])));

  a_r2_update_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && update_en) |=> $stable(up_vec));

  a_r2_update_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && update_en) |=> (up_vec == $past(sh_vec)));

  a_r8_unselected_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> $stable(sh_vec));

  a_r9_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    all_off |-> (pad_oe == '0));

  a_r4_pullup: assert property (@(posedge clk) disable iff (!rst_n)
    &(pad_out | pad_oe));
endmodule

bind bscan_chain bscan_chain_chk #(.L(L), .NB(NB_BIDIR)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sel       (sel),
  .capture_en(capture_en),
  .shift_en  (shift_en),
  .update_en (update_en),
  .scan_in   (scan_in),
  .all_off   (all_off),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe),
  .sh_vec    (sh_vec),
  .up_vec    (up_vec)
);

// File: tb/bscan_chain_bench.sv
module bscan_chain_bench;
  localparam int NBB = 4;
  localparam int NBI = 2;
  localparam int NBN = 1;
  localparam int L   = NBI + NBN + 3 * NBB;
  localparam int BB  = NBI + NBN;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 0, capture_en = 0, shift_en = 0, update_en = 0;
  logic [1:0] mode = 2'd0;
  logic scan_in = 0, all_off = 0;
  logic [NBB-1:0] core_out = '0, core_oe = '0, pad_in = '0;
  logic [NBI-1:0] ipad_in = '0;
  logic scan_out;
  logic [NBB-1:0] core_in, pad_out, pad_oe;
  logic [NBI-1:0] icore_in;

  always #5 clk = ~clk;

  bscan_chain #(.NB_BIDIR(NBB), .NB_INONLY(NBI), .NB_INTERNAL(NBN)) u_bscan_chain (
    .clk(clk), .rst_n(rst_n), .sel(sel), .capture_en(capture_en),
    .shift_en(shift_en), .update_en(update_en), .mode(mode),
    .scan_in(scan_in), .scan_out(scan_out), .all_off(all_off),
    .core_out(core_out), .core_oe(core_oe), .core_in(core_in),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .ipad_in(ipad_in), .icore_in(icore_in));

  int errors = 0;
  int checks = 0;
  string cur_req = "R3";
  bit done = 0;

  // Behavioural model: two bit queues, sh (serial) and up (parallel).
  bit msh[$];
  bit mup[$];

  // 0 input-only, 1 internal, 2 control, 3 output, 4 bidir input
  function automatic int role(int i);
    if (i < NBI) return 0;
    if (i < BB) return 1;
    return 2 + (i - BB) % 3;
  endfunction

  function automatic bit safe_of(int i);
    return (role(i) == 1 || role(i) == 2);
  endfunction

  task automatic model_reset();
    msh.delete(); mup.delete();
    for (int i = 0; i < L; i++) begin
      msh.push_back(1'b0);
      mup.push_back(safe_of(i));
    end
  endtask

  task automatic model_step();
    bit nsh[$];
    int p, r;
    bit takes;
    if (!rst_n) begin model_reset(); return; end
    nsh = msh;
    if (sel && capture_en) begin
      for (int i = 0; i < L; i++) begin
        r = role(i);
        p = (i - BB) / 3;
        if (r == 0 || r == 4) takes = (mode != 2'd2);
        else if (r == 1)      takes = 1'b1;
        else                  takes = (mode != 2'd1);
        if (takes) begin
          case (r)
            0: nsh[i] = ipad_in[i];
            1: nsh[i] = mup[i];
            2: nsh[i] = !core_oe[p];
            3: nsh[i] = core_out[p];
            default: nsh[i] = pad_in[p];
          endcase
        end
      end
    end else if (sel && shift_en) begin
      void'(nsh.pop_front());
      nsh.push_back(scan_in);
    end
    if (sel && update_en) mup = msh;
    msh = nsh;
  endtask

  task automatic chk(string what, int got, int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", cur_req, what, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit en, drv;
    int e_po = 0, e_oe = 0, e_ci = 0, e_ic = 0;
    for (int p = 0; p < NBB; p++) begin
      int b = BB + 3 * p;
      if (mode == 2'd1) begin en = !mup[b]; drv = mup[b+1]; end
      else              begin en = core_oe[p]; drv = core_out[p]; end
      en = en && !all_off;
      if (en) e_oe |= (1 << p);
      if (!en || drv) e_po |= (1 << p);
      if ((mode == 2'd2) ? mup[b+2] : pad_in[p]) e_ci |= (1 << p);
    end
    for (int j = 0; j < NBI; j++)
      if ((mode == 2'd2) ? mup[j] : ipad_in[j]) e_ic |= (1 << j);
    chk("scan_out", int'(scan_out), int'(msh[0]));
    chk("pad_out", int'(pad_out), e_po);
    chk("pad_oe", int'(pad_oe), e_oe);
    chk("core_in", int'(core_in), e_ci);
    chk("icore_in", int'(icore_in), e_ic);
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic strobe(bit c, bit s, bit u);
    capture_en = c; shift_en = s; update_en = u;
    tick();
    capture_en = 0; shift_en = 0; update_en = 0;
  endtask

  task automatic shift_word(logic [31:0] w);
    for (int i = 0; i < L; i++) begin
      scan_in = w[i];
      strobe(0, 1, 0);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    model_reset();
    mode = 2'd1;
    tick(); tick();
    // R3: safe state after reset, external test shows all pads disabled and pulled up
    cur_req = "R3";
    chk("pad_oe reset", int'(pad_oe), 0);
    chk("pad_out reset", int'(pad_out), (1 << NBB) - 1);
    rst_n = 1;
    tick();

    // R1 R2: load a pattern, the pads must not change until update
    cur_req = "R2";
    sel = 1;
    shift_word(32'h5A3C);
    cur_req = "R1";
    strobe(0, 0, 1);
    // R4: external test drives from update stages
    cur_req = "R4";
    tick();
    shift_word(32'h0000);
    strobe(0, 0, 1);
    tick();

    // R5: sample in functional mode
    cur_req = "R5";
    mode = 2'd0;
    core_out = 4'b1011; core_oe = 4'b0110; pad_in = 4'b1100; ipad_in = 2'b10;
    tick();
    strobe(1, 0, 0);
    shift_word(32'h7FFF);

    // R6: external test capture takes only inputs
    cur_req = "R6";
    mode = 2'd1;
    core_out = 4'b0100; core_oe = 4'b1001; pad_in = 4'b0011; ipad_in = 2'b01;
    strobe(1, 0, 0);
    shift_word(32'h1234);

    // R7: internal test capture keeps inputs, core sees update stages
    cur_req = "R7";
    mode = 2'd2;
    shift_word(32'h6DB6);
    strobe(0, 0, 1);
    pad_in = 4'b1010; ipad_in = 2'b11; core_out = 4'b1110; core_oe = 4'b0011;
    strobe(1, 0, 0);
    shift_word(32'h0F0F);

    // R10: internal cells reload their own update value
    cur_req = "R10";
    mode = 2'd0;
    shift_word(32'h2AAA);
    strobe(0, 0, 1);
    strobe(1, 0, 0);
    shift_word(32'h0000);

    // R11: capture beats shift
    cur_req = "R11";
    pad_in = 4'b0101; core_out = 4'b0011;
    strobe(1, 1, 0);
    shift_word(32'h0000);

    // R8: deselected, strobes ignored
    cur_req = "R8";
    shift_word(32'h4321);
    sel = 0;
    scan_in = 1;
    strobe(1, 0, 0);
    strobe(0, 1, 0);
    strobe(0, 0, 1);
    sel = 1;
    shift_word(32'h0000);

    // R9: global disable in every mode
    cur_req = "R9";
    all_off = 1;
    for (int m = 0; m < 4; m++) begin
      mode = 2'(m);
      core_oe = 4'hF;
      tick();
    end
    all_off = 0;

    // mixed phase over all modes and strobes
    cur_req = "R5";
    for (int n = 0; n < 400; n++) begin
      sel = ($urandom % 5) != 0;
      mode = 2'($urandom % 4);
      all_off = ($urandom % 9) == 0;
      core_out = 4'($urandom); core_oe = 4'($urandom);
      pad_in = 4'($urandom); ipad_in = 2'($urandom);
      scan_in = 1'($urandom);
      capture_en = ($urandom % 6) == 0;
      shift_en = ($urandom % 2) == 0;
      update_en = ($urandom % 7) == 0;
      tick();
    end
    capture_en = 0; shift_en = 0; update_en = 0;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule